// File: doc/BRIEF.md
# Indexed Dual-Bank Clock RAM Port

This block lets a host reach a real-time-clock register file and its battery-backed byte store through two index/data port pairs. Storage is two banks of 128 bytes, a standard bank and an extended bank. In the standard bank, locations 00h–09h hold the time, date and alarm bytes, 0Ah–0Dh hold four clock control registers, and 0Eh–7Fh are general user bytes. The extended bank is 128 plain user bytes.

The host sees four byte-wide offsets, decoded from the two low address bits. An even offset loads the bank's index register. The odd offset above it reads or writes the byte that index selects. Offsets 0/1 serve the standard bank and offsets 2/3 serve the extended bank. When the extended bank is switched off, offsets 2/3 fold onto offsets 0/1. The timekeeping logic is outside the block. It supplies an update-busy flag, and while that flag is high, host writes to the time/date bytes are dropped. A clock-enable configuration input shuts off data access to the standard bank and leaves the extended bank usable.

Top module: `rtc_idx_ram`

## Requirements
- R1: After reset both index registers are 0 and `bus_rdata` is 00h. Storage contents are not changed by reset.
- R2: A write to offset 0 (or offset 2 with the extended bank enabled) loads bits 6:0 of the byte into that bank's index, and bit 7 is dropped. A read of an even offset returns the index zero-extended to 8 bits.
- R3: A write to offset 1 stores the byte at the standard index on the clock edge that ends the write strobe. A later read of offset 1 returns it.
- R4: With `ext_en`=1, offsets 2/3 use their own index and the extended array, and the standard bank is left untouched.
- R5: With `ext_en`=0, offsets 2 and 3 behave exactly as offsets 0 and 1. The extended index and array do not change.
- R6: While `upd_busy`=1, standard-bank data writes to indexes 00h–09h are dropped. Writes to 0Ah and above still take effect.
- R7: `upd_busy` has no effect on extended-bank writes, including at indexes 00h–09h.
- R8: While `rtc_on`=0, standard-bank data writes are dropped and standard-bank data reads return FFh. Extended-bank access still works. Index loads still work.
- R9: A read strobe in cycle n updates `bus_rdata` at the end of cycle n. `bus_rdata` holds its value until the next read.
- R10: If `bus_rd` and `bus_wr` are both high, only the write is done and `bus_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port offset 0..3 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| ext_en | input | 1 | 1 = offsets 2/3 address the extended bank |
| rtc_on | input | 1 | 1 = clock function enabled (standard data access allowed) |
| upd_busy | input | 1 | Update cycle in progress |

## Verification
A host write to a time/date byte can land in the same cycle that the update-busy flag is high, or in the cycle where the flag rises or falls. The bench raises and lowers `upd_busy` on the same falling edge that presents the write, and also in random cycles. A read of the same index afterwards must show the old byte for 00h–09h and the new byte for 0Ah and above. A read and a write strobe can also coincide. In that case the bench expects the write to land and `bus_rdata` to stay unchanged.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;

   typedef enum logic {
      BANK_STD = 1'b0,
      BANK_EXT = 1'b1
   } bank_e;

   // one decoded host access
   typedef struct packed {
      logic  idx_wr;
      logic  idx_rd;
      logic  dat_wr;
      logic  dat_rd;
      bank_e bank;
   } acc_t;

   localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/rtc_idx_decode.sv
module rtc_idx_decode
   import rtc_idx_pkg::*;
(
   input  logic [1:0] addr,
   input  logic       wr,
   input  logic       rd,
   input  logic       ext_en,
   output acc_t       acc
);

   logic rd_only;

   always_comb begin
      rd_only    = rd & ~wr;            // write wins on a collision
      acc.bank   = (addr[1] & ext_en) ? BANK_EXT : BANK_STD;
      acc.idx_wr = wr      & ~addr[0];
      acc.dat_wr = wr      &  addr[0];
      acc.idx_rd = rd_only & ~addr[0];
      acc.dat_rd = rd_only &  addr[0];
   end

endmodule

// File: rtl/rtc_idx_index.sv
module rtc_idx_index #(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din;
   end

endmodule

// File: rtl/rtc_idx_bank.sv
module rtc_idx_bank #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IDX_W      = 7,
   parameter int unsigned GUARD_LOCS = 0
) (
   input  logic              clk,
   input  logic              we,
   input  logic              guard,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned   DEPTH     = 1 << IDX_W;
   localparam logic [IDX_W:0] GUARD_LIM = (IDX_W+1)'(GUARD_LOCS);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              in_guard;
   logic              accept;

   // no reset: contents model battery-backed storage
   always_comb begin
      in_guard = ({1'b0, idx} < GUARD_LIM);
      accept   = we & ~(guard & in_guard);
   end

   always_ff @(posedge clk) begin
      if (accept) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/rtc_idx_ram.sv
module rtc_idx_ram
   import rtc_idx_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned TIME_LOCS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_en,
   input  logic              rtc_on,
   input  logic              upd_busy
);

   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned PAD_W = DATA_W - IDX_W;

   if (DATA_W <= IDX_W) begin : g_bad_width
      $error("rtc_idx_ram: DATA_W must exceed IDX_W");
   end
   if (TIME_LOCS > DEPTH) begin : g_bad_guard
      $error("rtc_idx_ram: TIME_LOCS exceeds bank depth");
   end

   acc_t              acc;
   logic [IDX_W-1:0]  idx_q   [NUM_BANKS];
   logic [DATA_W-1:0] rd_word [NUM_BANKS];
   logic [DATA_W-1:0] rd_next;
   logic              bsel;
   logic [IDX_W-1:0]  std_idx;
   logic [IDX_W-1:0]  ext_idx;

   rtc_idx_decode u_dec (
      .addr   (bus_addr),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .ext_en (ext_en),
      .acc    (acc)
   );

   assign bsel = acc.bank;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam bit          IS_STD = (b == 0);
      localparam int unsigned GUARD  = IS_STD ? TIME_LOCS : 0;
      logic hit;
      logic we;

      assign hit = (int'(bsel) == b);
      if (IS_STD) begin : g_std_gate
         assign we = acc.dat_wr & hit & rtc_on;
      end else begin : g_ext_gate
         assign we = acc.dat_wr & hit;
      end

      rtc_idx_index #(.IDX_W(IDX_W)) u_idx (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (acc.idx_wr & hit),
         .din   (bus_wdata[IDX_W-1:0]),
         .idx   (idx_q[b])
      );

      rtc_idx_bank #(
         .DATA_W     (DATA_W),
         .IDX_W      (IDX_W),
         .GUARD_LOCS (GUARD)
      ) u_mem (
         .clk   (clk),
         .we    (we),
         .guard (upd_busy),
         .idx   (idx_q[b]),
         .wdata (bus_wdata),
         .rdata (rd_word[b])
      );
   end

   assign std_idx = idx_q[0];
   assign ext_idx = idx_q[1];

   always_comb begin
      if (acc.idx_rd)
         rd_next = {{PAD_W{1'b0}}, idx_q[bsel]};
      else if (bsel == BANK_STD && !rtc_on)
         rd_next = '1;
      else
         rd_next = rd_word[bsel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bus_rdata <= '0;
      else if (acc.idx_rd | acc.dat_rd) bus_rdata <= rd_next;
   end

endmodule

// File: rtl/rtc_idx_ram_chk.sv
module rtc_idx_ram_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [IDX_W-1:0]  idx_byte,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ext_en,
   input logic              rtc_on,
   input logic [IDX_W-1:0]  std_idx,
   input logic [IDX_W-1:0]  ext_idx
);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr) |=> $stable(bus_rdata));

   p_off_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr[0] && !rtc_on && !(bus_addr[1] && ext_en))
      |=> (bus_rdata == '1));

   p_std_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr[0] && !(bus_addr[1] && ext_en))
      |=> (std_idx == $past(idx_byte)));

   p_alias_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr[0] && bus_addr[1] && !ext_en) |=> $stable(ext_idx));

   p_idx_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && !bus_addr[0]) |=> (bus_rdata[DATA_W-1] == 1'b0));

endmodule

bind rtc_idx_ram rtc_idx_ram_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .idx_byte  (bus_wdata[IDX_W-1:0]),
   .bus_rdata (bus_rdata),
   .ext_en    (ext_en),
   .rtc_on    (rtc_on),
   .std_idx   (std_idx),
   .ext_idx   (ext_idx)
);

// File: tb/rtc_idx_ram_bench.sv
`timescale 1ns/1ps
module rtc_idx_ram_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_en = 1'b1;
   logic       rtc_on = 1'b1;
   logic       upd_busy = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // bench model
   logic [6:0] m_idx [2];
   logic [7:0] m_mem [2][128];
   bit         m_ok  [2][128];
   logic [7:0] last_rd;

   always #10 clk = ~clk;

   rtc_idx_ram u_rtc_idx_ram (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_en(ext_en), .rtc_on(rtc_on), .upd_busy(upd_busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic int eff_bank(input logic [1:0] a);
      return (a[1] && ext_en) ? 1 : 0;
   endfunction

   // expected read result; known=0 when the byte was never written
   function automatic logic [7:0] exp_read(input logic [1:0] a, output bit known);
      int b = eff_bank(a);
      known = 1'b1;
      if (!a[0])                 return {1'b0, m_idx[b]};
      if (b == 0 && !rtc_on)     return 8'hFF;
      known = m_ok[b][m_idx[b]];
      return m_mem[b][m_idx[b]];
   endfunction

   function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
      int b = eff_bank(a);
      if (!a[0]) begin
         m_idx[b] = d[6:0];
      end else if (!(b == 0 && !rtc_on) && !(b == 0 && upd_busy && m_idx[0] < 7'd10)) begin
         m_mem[b][m_idx[b]] = d;
         m_ok[b][m_idx[b]]  = 1'b1;
      end
   endfunction

   // one access: inputs set at negedge, result sampled at next negedge
   task automatic op(input logic [1:0] a, input bit w, input bit r,
                     input logic [7:0] d, input string req);
      bit         known;
      logic [7:0] exp;
      exp = exp_read(a, known);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (w) model_write(a, d);
      if (r && !w) begin
         if (known) check(bus_rdata === exp, req, bus_rdata, exp);
         last_rd = bus_rdata;
      end else begin
         check(bus_rdata === last_rd, {req, " R9/R10 hold"}, bus_rdata, last_rd);
      end
   endtask

   task automatic rd_expect(input logic [1:0] a, input logic [7:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      check(bus_rdata === exp, req, bus_rdata, exp);
      last_rd = bus_rdata;
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_idx[0] = '0; m_idx[1] = '0;
      foreach (m_ok[b, i]) m_ok[b][i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(bus_rdata === 8'h00, "R1 rdata", bus_rdata, 8'h00);
      last_rd = 8'h00;
      rd_expect(2'd0, 8'h00, "R1 std index");
      rd_expect(2'd2, 8'h00, "R1 ext index");
      // R2 top bit of index dropped
      op(2'd0, 1, 0, 8'h85, "R2");
      rd_expect(2'd0, 8'h05, "R2 index read");
      // R3 data write/read
      op(2'd0, 1, 0, 8'h20, "R3");
      op(2'd1, 1, 0, 8'hAA, "R3");
      rd_expect(2'd1, 8'hAA, "R3 readback");
      // R4 separate extended bank
      op(2'd2, 1, 0, 8'h20, "R4");
      op(2'd3, 1, 0, 8'h55, "R4");
      rd_expect(2'd3, 8'h55, "R4 ext readback");
      rd_expect(2'd1, 8'hAA, "R4 std untouched");
      // R5 alias when extended bank disabled
      ext_en = 1'b0;
      op(2'd2, 1, 0, 8'h30, "R5");
      op(2'd3, 1, 0, 8'h77, "R5");
      rd_expect(2'd0, 8'h30, "R5 alias index");
      rd_expect(2'd1, 8'h77, "R5 alias data");
      ext_en = 1'b1;
      rd_expect(2'd2, 8'h20, "R5 ext index kept");
      rd_expect(2'd3, 8'h55, "R5 ext data kept");
      // R6 update blocks time bytes only
      op(2'd0, 1, 0, 8'h09, "R6");
      op(2'd1, 1, 0, 8'h22, "R6");
      upd_busy = 1'b1;
      op(2'd1, 1, 0, 8'h11, "R6");
      rd_expect(2'd1, 8'h22, "R6 time byte kept");
      op(2'd0, 1, 0, 8'h0A, "R6");
      op(2'd1, 1, 0, 8'h33, "R6");
      rd_expect(2'd1, 8'h33, "R6 control byte written");
      // R7 extended low bytes not guarded
      op(2'd2, 1, 0, 8'h05, "R7");
      op(2'd3, 1, 0, 8'h44, "R7");
      rd_expect(2'd3, 8'h44, "R7 ext low write");
      upd_busy = 1'b0;
      // R8 clock disabled
      rtc_on = 1'b0;
      op(2'd1, 1, 0, 8'h99, "R8");
      rd_expect(2'd1, 8'hFF, "R8 std read FF");
      op(2'd3, 1, 0, 8'h66, "R8");
      rd_expect(2'd3, 8'h66, "R8 ext works");
      rtc_on = 1'b1;
      rd_expect(2'd1, 8'h33, "R8 std write dropped");
      // R9 hold over idle cycles
      repeat (4) @(negedge clk);
      check(bus_rdata === last_rd, "R9 idle hold", bus_rdata, last_rd);
      // R10 collision
      op(2'd1, 1, 1, 8'hC3, "R10");
      rd_expect(2'd1, 8'hC3, "R10 write landed");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] a  = 2'($urandom_range(0, 3));
         int         k  = $urandom_range(0, 9);
         logic [7:0] d  = 8'($urandom);
         if ($urandom_range(0, 7) == 0) upd_busy = ~upd_busy;
         if ($urandom_range(0, 15) == 0) ext_en = ~ext_en;
         if ($urandom_range(0, 15) == 0) rtc_on = ~rtc_on;
         if (!a[0] && k < 5) d = {d[7], 3'b000, d[3:0]};  // bias toward time bytes
         if (k < 4)       op(a, 1, 0, d, "R3/R6/R8 rand wr");
         else if (k < 9)  op(a, 0, 1, d, "R2/R4/R5 rand rd");
         else             op(a, 1, 1, d, "R10 rand");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule